// File: doc/BRIEF.md
# Transceiver Lane Datapath Reset Sequencer

This block runs the reset procedure for the transmit or receive datapath of one serial transceiver lane. It watches for events that leave the datapath in an undefined state: a strobe announcing a new line rate, a strobe announcing that the user clock feeding the datapath has changed and, in the receive variant, the loss of clock-data-recovery lock. Any of these starts a sequence. The sequencer moves the lane's two-bit power-down control into its reset setting and waits for the lane to acknowledge. It then pulses the elastic-buffer reset and returns the lane to normal operation.

The handshake runs on the control clock (`clk_ctl`). The buffer-reset pulse is produced on the datapath user clock (`clk_usr`). A toggle request crosses to the user-clock side, where it becomes a single-cycle pulse. A toggle completion then returns to the control side. A trigger that arrives while a sequence is running is remembered, and one more full sequence runs afterwards. If the acknowledge never comes, a timeout ends the wait, raises an error flag and puts the lane back to normal. No buffer reset is issued in that case.

Top module: `lane_rst_seq`

## Requirements
- R1: A one-cycle high strobe on `rate_chg` or on `uclk_chg` while idle makes `pwr_ctl` read 2'b10 after the next `clk_ctl` rising edge, and `busy` goes high.
- R2: With `IS_RX`=1, a high-to-low transition of `cdr_lock` starts a sequence. A low-to-high transition starts none.
- R3: `pwr_ctl` only ever takes the values 2'b00 (normal) and 2'b10 (reset). It holds 2'b10 from the start of a sequence until the sequence ends.
- R4: The sequencer advances only on a rising edge of `ctl_ack` seen after the sequence has started. An acknowledge that is already high when the sequence starts does not count.
- R5: An acknowledge that stays high for several `clk_ctl` cycles produces exactly one buffer reset.
- R6: Each acknowledged sequence drives `buf_rst` high for exactly one `clk_usr` cycle, and only while `pwr_ctl` is 2'b10.
- R7: After the buffer-reset pulse has completed, `pwr_ctl` returns to 2'b00, `busy` falls, `ready` is high and `timeout_err` is low.
- R8: Any number of triggers that arrive while a sequence runs cause exactly one further full sequence after the current one.
- R9: If no acknowledge edge arrives, `pwr_ctl` stays at 2'b10 for exactly `TIMEOUT_CYC` `clk_ctl` cycles and then returns to 2'b00. At that point `timeout_err` is set, `ready` is low and no buffer reset is issued. The next sequence start clears `timeout_err`.
- R10: While `rst` is high, the outputs read `pwr_ctl`=2'b00, with `buf_rst`, `busy`, `ready` and `timeout_err` all low. `ready` stays low until one sequence has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctl | input | 1 | Control clock for the handshake and the state machine |
| clk_usr | input | 1 | Datapath user clock for the buffer-reset pulse |
| rst | input | 1 | Active-high synchronous reset; held for several cycles of both clocks |
| rate_chg | input | 1 | One-cycle strobe: line rate was changed |
| uclk_chg | input | 1 | One-cycle strobe: user clock source was changed |
| cdr_lock | input | 1 | Receive lock status; falling edge triggers in the receive variant |
| ctl_ack | input | 1 | Lane control acknowledge, may stay high for several cycles |
| pwr_ctl | output | 2 | Power-down control to the lane: 2'b00 normal, 2'b10 reset |
| buf_rst | output | 1 | Elastic-buffer reset, one `clk_usr` cycle wide |
| busy | output | 1 | A sequence is in progress |
| ready | output | 1 | Idle, with the last sequence completed successfully |
| timeout_err | output | 1 | The last sequence timed out waiting for the acknowledge |

## Verification
The main flow is swept over a grid of acknowledge delays and acknowledge lengths. Long acknowledges separate single from repeated buffer resets, and short delays expose missed edges. An acknowledge held high before the start is distinguished from a real edge because it must end in a timeout. Bursts of triggers during a busy sequence show whether they collapse into one follow-up sequence. A lane that never responds gives an exact count of the reset-setting cycles, which pins the timeout length.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_ACK = 2'd1,
    ST_BUF      = 2'd2
  } seq_st_e;

  localparam logic [1:0] PD_NORMAL = 2'b00;
  localparam logic [1:0] PD_RESET  = 2'b10;
endpackage

// File: rtl/lrs_trig.sv
module lrs_trig #(
  parameter bit IS_RX = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_chg,
  input  logic uclk_chg,
  input  logic cdr_lock,
  output logic trig
);
  logic lock_loss;

  generate
    if (IS_RX) begin : g_rx
      logic lock_q;
      always_ff @(posedge clk) begin
        if (rst) lock_q <= 1'b0;
        else     lock_q <= cdr_lock;
      end
      assign lock_loss = lock_q & ~cdr_lock;
    end else begin : g_tx
      logic unused_lock;
      assign unused_lock = cdr_lock;
      assign lock_loss   = 1'b0;
    end
  endgenerate

  assign trig = rate_chg | uclk_chg | lock_loss;
endmodule

// File: rtl/lrs_edge.sv
module lrs_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/lrs_xpulse.sv
module lrs_xpulse #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic clk_dst,
  input  logic rst,
  input  logic fire,
  output logic dst_pulse,
  output logic src_done
);
  localparam int S = SYNC_STAGES;

  logic         req_tgl;
  logic         done_tgl;
  logic [S:0]   rq_sync;
  logic [S:0]   dn_sync;

  // request toggle, source side
  always_ff @(posedge clk_src) begin
    if (rst)       req_tgl <= 1'b0;
    else if (fire) req_tgl <= ~req_tgl;
  end

  // destination side: synchronise, pulse, return toggle after the pulse
  always_ff @(posedge clk_dst) begin
    if (rst) begin
      rq_sync   <= '0;
      dst_pulse <= 1'b0;
      done_tgl  <= 1'b0;
    end else begin
      rq_sync   <= {rq_sync[S-1:0], req_tgl};
      dst_pulse <= rq_sync[S] ^ rq_sync[S-1];
      done_tgl  <= rq_sync[S];
    end
  end

  // completion back to the source side
  always_ff @(posedge clk_src) begin
    if (rst) dn_sync <= '0;
    else     dn_sync <= {dn_sync[S-1:0], done_tgl};
  end

  assign src_done = dn_sync[S] ^ dn_sync[S-1];
endmodule

// File: rtl/lane_rst_seq.sv
module lane_rst_seq
  import lrs_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1024,
  parameter bit IS_RX       = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_ctl,
  input  logic       clk_usr,
  input  logic       rst,
  input  logic       rate_chg,
  input  logic       uclk_chg,
  input  logic       cdr_lock,
  input  logic       ctl_ack,
  output logic [1:0] pwr_ctl,
  output logic       buf_rst,
  output logic       busy,
  output logic       ready,
  output logic       timeout_err
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYC - 1);

  seq_st_e       st;
  logic [CW-1:0] wait_cnt;
  logic          pend;
  logic          err_q;
  logic          ok_q;
  logic          trig;
  logic          ack_rise;
  logic          fire;
  logic          xdone;
  logic          start;

  lrs_trig #(.IS_RX(IS_RX)) u_trig (
    .clk      (clk_ctl),
    .rst      (rst),
    .rate_chg (rate_chg),
    .uclk_chg (uclk_chg),
    .cdr_lock (cdr_lock),
    .trig     (trig)
  );

  lrs_edge u_ack (
    .clk  (clk_ctl),
    .rst  (rst),
    .lvl  (ctl_ack),
    .rise (ack_rise)
  );

  lrs_xpulse #(.SYNC_STAGES(SYNC_STAGES)) u_x (
    .clk_src   (clk_ctl),
    .clk_dst   (clk_usr),
    .rst       (rst),
    .fire      (fire),
    .dst_pulse (buf_rst),
    .src_done  (xdone)
  );

  assign fire  = (st == ST_WAIT_ACK) && ack_rise;
  assign start = trig || pend;

  always_ff @(posedge clk_ctl) begin
    if (rst) begin
      st       <= ST_IDLE;
      wait_cnt <= '0;
      pend     <= 1'b0;
      err_q    <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      // a trigger during a running sequence is remembered once
      if (st != ST_IDLE) begin
        if (trig) pend <= 1'b1;
      end else begin
        pend <= 1'b0;
      end

      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st       <= ST_WAIT_ACK;
            wait_cnt <= '0;
            err_q    <= 1'b0;
            ok_q     <= 1'b0;
          end
        end
        ST_WAIT_ACK: begin
          if (ack_rise) begin
            st <= ST_BUF;
          end else if (wait_cnt == CNT_LAST) begin
            st    <= ST_IDLE;
            err_q <= 1'b1;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_BUF: begin
          if (xdone) begin
            st   <= ST_IDLE;
            ok_q <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign pwr_ctl     = (st == ST_IDLE) ? PD_NORMAL : PD_RESET;
  assign busy        = (st != ST_IDLE);
  assign ready       = (st == ST_IDLE) && ok_q;
  assign timeout_err = err_q;
endmodule

// File: rtl/lrs_chk.sv
module lrs_chk (
  input logic       clk_ctl,
  input logic       clk_usr,
  input logic       rst,
  input logic [1:0] pwr_ctl,
  input logic       buf_rst,
  input logic       busy,
  input logic       ready,
  input logic       timeout_err
);
  a_r3_pwr_legal: assert property (@(posedge clk_ctl) disable iff (rst)
    (pwr_ctl == 2'b00) || (pwr_ctl == 2'b10));

  a_r6_buf_single: assert property (@(posedge clk_usr) disable iff (rst)
    buf_rst |=> !buf_rst);

  a_r6_buf_in_reset: assert property (@(posedge clk_usr) disable iff (rst)
    buf_rst |-> (pwr_ctl == 2'b10));

  a_r7_ready_normal: assert property (@(posedge clk_ctl) disable iff (rst)
    ready |-> (pwr_ctl == 2'b00) && !timeout_err && !busy);

  a_r9_timeout_release: assert property (@(posedge clk_ctl) disable iff (rst)
    $rose(timeout_err) |-> (pwr_ctl == 2'b00) && !ready);
endmodule

bind lane_rst_seq lrs_chk u_chk (.*);

// File: tb/sim_lane_rst_seq.sv
module sim_lane_rst_seq;
  localparam int CLK_PERIOD  = 10;
  localparam int UCLK_PERIOD = 14;
  localparam int TMO         = 16;

  logic       clk_ctl = 1'b0;
  logic       clk_usr = 1'b0;
  logic       rst = 1'b1;
  logic       rate_chg = 1'b0;
  logic       uclk_chg = 1'b0;
  logic       cdr_lock = 1'b0;
  logic       ctl_ack;
  logic [1:0] pwr_ctl;
  logic       buf_rst;
  logic       busy;
  logic       ready;
  logic       timeout_err;

  int checks = 0;
  int errors = 0;
  int seq_cnt = 0;
  int pulses = 0;
  int hi_cnt = 0;
  int wd = 0;
  logic pwr_q = 1'b0;
  logic buf_q = 1'b0;

  bit resp_en = 1'b1;
  bit force_ack = 1'b0;
  bit resp_ack = 1'b0;
  int ack_dly = 2;
  int ack_len = 1;
  int rc = 0;

  always #(CLK_PERIOD/2)  clk_ctl = ~clk_ctl;
  always #(UCLK_PERIOD/2) clk_usr = ~clk_usr;

  assign ctl_ack = force_ack | resp_ack;

  lane_rst_seq #(.TIMEOUT_CYC(TMO), .IS_RX(1'b1), .SYNC_STAGES(2)) u0 (
    .clk_ctl(clk_ctl), .clk_usr(clk_usr), .rst(rst),
    .rate_chg(rate_chg), .uclk_chg(uclk_chg), .cdr_lock(cdr_lock),
    .ctl_ack(ctl_ack), .pwr_ctl(pwr_ctl), .buf_rst(buf_rst),
    .busy(busy), .ready(ready), .timeout_err(timeout_err)
  );

  // behavioural lane acknowledge
  always @(negedge clk_ctl) begin
    if (resp_en && pwr_ctl == 2'b10) begin
      rc = rc + 1;
      resp_ack = (rc >= ack_dly) && (rc < ack_dly + ack_len);
    end else begin
      rc = 0;
      resp_ack = 1'b0;
    end
  end

  // count sequences (entries into the reset setting)
  always @(negedge clk_ctl) begin
    if (!rst) begin
      if (pwr_ctl[1] && !pwr_q) seq_cnt = seq_cnt + 1;
      pwr_q = pwr_ctl[1];
    end
  end

  // count buffer-reset pulses and their width
  always @(negedge clk_usr) begin
    if (!rst) begin
      if (buf_rst) begin
        hi_cnt = hi_cnt + 1;
        if (!buf_q) pulses = pulses + 1;
        checks = checks + 1;
        if (pwr_ctl != 2'b10) begin
          errors = errors + 1;
          $display("FAIL R6 buf_rst outside reset setting: pwr_ctl=%b expected 10", pwr_ctl);
        end
      end
      buf_q = buf_rst;
    end
  end

  always @(posedge clk_ctl) begin
    wd = wd + 1;
    if (wd > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: cycles=%0d expected below 150000", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    int quiet = 0;
    int n = 0;
    while (quiet < 40 && n < 5000) begin
      @(negedge clk_ctl);
      n++;
      if (!busy) quiet++; else quiet = 0;
    end
  endtask

  task automatic strobe_rate();
    @(negedge clk_ctl);
    rate_chg = 1'b1;
    @(negedge clk_ctl);
    rate_chg = 1'b0;
  endtask

  initial begin
    int s0, p0, h0, n10;
    repeat (6) @(negedge clk_usr);
    // R10: reset values
    check(pwr_ctl == 2'b00, "R10 pwr_ctl in reset", pwr_ctl, 0);
    check(!buf_rst && !busy, "R10 buf_rst/busy in reset", {buf_rst, busy}, 0);
    check(!ready && !timeout_err, "R10 ready/err in reset", {ready, timeout_err}, 0);
    @(negedge clk_ctl);
    rst = 1'b0;
    cdr_lock = 1'b1;
    repeat (10) @(negedge clk_ctl);
    check(!ready && !busy, "R10 not ready before first sequence", {ready, busy}, 0);
    check(seq_cnt == 0, "R2 rising lock at start no trigger", seq_cnt, 0);

    // R1: uclk_chg strobe, exact start cycle
    @(negedge clk_ctl);
    uclk_chg = 1'b1;
    @(negedge clk_ctl);
    uclk_chg = 1'b0;
    check(pwr_ctl == 2'b10, "R1 pwr_ctl after uclk_chg", pwr_ctl, 2);
    check(busy, "R1 busy after uclk_chg", busy, 1);
    wait_idle();
    check(ready && !timeout_err, "R7 ready after uclk_chg sequence", {ready, timeout_err}, 2);
    check(pulses == 1 && hi_cnt == 1, "R6 one pulse one cycle", hi_cnt, 1);

    // R4 R5 R6 R7: sweep acknowledge delay and length
    for (int d = 1; d <= 4; d++) begin
      for (int l = 1; l <= 5; l++) begin
        ack_dly = d;
        ack_len = l;
        s0 = seq_cnt; p0 = pulses; h0 = hi_cnt;
        strobe_rate();
        check(pwr_ctl == 2'b10, "R1 pwr_ctl after rate_chg", pwr_ctl, 2);
        wait_idle();
        check(seq_cnt - s0 == 1, "R3 one sequence per trigger", seq_cnt - s0, 1);
        check(pulses - p0 == 1, "R5 one buf reset per held ack", pulses - p0, 1);
        check(hi_cnt - h0 == 1, "R6 buf_rst one user cycle", hi_cnt - h0, 1);
        check(pwr_ctl == 2'b00 && ready && !timeout_err, "R7 normal and ready",
              {pwr_ctl, ready, timeout_err}, 2);
      end
    end
    ack_dly = 2; ack_len = 3;

    // R2: loss of lock triggers, regain does not
    s0 = seq_cnt; p0 = pulses;
    @(negedge clk_ctl);
    cdr_lock = 1'b0;
    @(negedge clk_ctl);
    check(pwr_ctl == 2'b10, "R2 lock loss starts sequence", pwr_ctl, 2);
    wait_idle();
    check(seq_cnt - s0 == 1 && pulses - p0 == 1, "R2 lock loss full sequence", pulses - p0, 1);
    s0 = seq_cnt;
    @(negedge clk_ctl);
    cdr_lock = 1'b1;
    wait_idle();
    check(seq_cnt == s0 && !busy, "R2 lock regain ignored", seq_cnt - s0, 0);

    // R8: several triggers during a sequence collapse to one extra
    ack_dly = 4;
    s0 = seq_cnt; p0 = pulses;
    strobe_rate();
    @(negedge clk_ctl); rate_chg = 1'b1;
    @(negedge clk_ctl); rate_chg = 1'b0;
    @(negedge clk_ctl); uclk_chg = 1'b1;
    @(negedge clk_ctl); uclk_chg = 1'b0;
    @(negedge clk_ctl); rate_chg = 1'b1;
    @(negedge clk_ctl); rate_chg = 1'b0;
    wait_idle();
    check(seq_cnt - s0 == 2, "R8 pending gives one extra sequence", seq_cnt - s0, 2);
    check(pulses - p0 == 2, "R8 two buffer resets", pulses - p0, 2);
    check(ready, "R8 ready after both", ready, 1);
    ack_dly = 2;

    // R9: no acknowledge -> timeout of exactly TMO cycles
    resp_en = 1'b0;
    p0 = pulses;
    n10 = 0;
    @(negedge clk_ctl);
    rate_chg = 1'b1;
    @(negedge clk_ctl);
    rate_chg = 1'b0;
    while (pwr_ctl == 2'b10 && n10 < 1000) begin
      n10++;
      @(negedge clk_ctl);
    end
    check(n10 == TMO, "R9 reset setting held for timeout", n10, TMO);
    check(timeout_err && !ready && !busy, "R9 error flag, not ready",
          {timeout_err, ready, busy}, 4);
    wait_idle();
    check(pulses == p0, "R9 no buffer reset on timeout", pulses - p0, 0);

    // R4: acknowledge already high at start is not an edge
    force_ack = 1'b1;
    repeat (3) @(negedge clk_ctl);
    p0 = pulses;
    strobe_rate();
    wait_idle();
    check(timeout_err && pulses == p0, "R4 stale ack ignored", pulses - p0, 0);
    force_ack = 1'b0;

    // R9: next good sequence clears the error
    resp_en = 1'b1;
    p0 = pulses;
    strobe_rate();
    check(!timeout_err, "R9 error cleared at start", timeout_err, 0);
    wait_idle();
    check(ready && pulses - p0 == 1, "R9 recovery completes", pulses - p0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule